// File: doc/BRIEF.md
# History-Based Memory Command Arbiter

This block sits between two reorder queues, one holding pending reads and one holding pending writes, and a downstream memory command queue that accepts entries strictly in arrival order. Each clock cycle it looks at the head candidate offered by each reorder queue. Every candidate is described by its direction and by a DRAM location made of rank, bank and port. The arbiter forwards at most one candidate to the memory queue.

The arbiter keeps a record of the last two commands it sent. That record is its state. For any state, a fixed ranking decides between the two candidates. The ranking uses two measures. The first is a conflict cost of each candidate against the recorded history. The second is how far the stream sent so far has moved from a programmed read-to-write ratio. A configuration input chooses which measure leads and which one only breaks ties.

The arbiter never holds a command back to wait for a conflict to clear. When anything is offered and the memory queue can accept, a command goes out, which keeps the memory queue full.

Top module: `mem_hist_arbiter`

## Requirements
- R1: While reset is held, and right after it is released, `mq_valid`, `rq_ready` and `wq_ready` are low when no candidate is offered. Reset leaves the history empty and the mix balance at zero. The first contest after reset between two zero-cost candidates is therefore won by the read.
- R2: When only one reorder queue offers a candidate and `mq_ready` is high, that candidate is issued whatever its cost or the mix state.
- R3: When neither queue offers a candidate, `mq_valid` is low, neither ready is raised, and the history and mix balance stay as they were.
- R4: A command issues only in a cycle where `mq_ready` is high; that issue is signalled by `rq_ready` or `wq_ready`. With `mq_ready` low both readies stay low and no state changes. History and balance update on the clock edge of the issuing cycle.
- R5: The conflict cost of a candidate is the sum of the following terms:
  - 2 if its rank and bank equal those of the last issued command.
  - 1 if its rank and bank equal those of the command issued before that.
  - 1 if it is a read, the last command was a write, and both use the same rank.
  - 1 if it is a write, the last command was a read, and the ports differ.
  
  A term applies only when the matching history entry exists.
- R6: With `cfg_mix_first` low, the candidate with the lower cost wins. On equal cost the mix preference (R8) decides, and with no preference the read wins.
- R7: With `cfg_mix_first` high, the mix preference (R8) decides. With no preference the lower cost wins, and on equal cost the read wins.
- R8: A signed balance of `BAL_W` bits works as follows:
  - An issued read adds the write weight to it.
  - An issued write subtracts the read weight from it.
  - A weight of 0 counts as 1.
  - The balance saturates at its signed limits (-32 and +31 by default).
  - A negative balance prefers reads, a positive balance prefers writes, and zero states no preference.
- R9: The history is two deep. On each issue the last entry moves to the second slot and the issued command becomes the last entry.
- R10: Whenever a candidate is offered and `mq_ready` is high, exactly one command is issued in that cycle.
- R11: `rq_ready` and `wq_ready` are never both high. `mq_write` is 1 for a write and 0 for a read. `mq_rank`, `mq_bank` and `mq_port` equal the fields of the chosen candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mix_first | input | 1 | 0: cost leads, mix breaks ties; 1: mix leads, cost breaks ties |
| cfg_rd_weight | input | WGT_W | Reads wanted per ratio period (0 counts as 1) |
| cfg_wr_weight | input | WGT_W | Writes wanted per ratio period (0 counts as 1) |
| rq_valid | input | 1 | Read candidate present |
| rq_rank | input | log2(RANKS) | Read candidate rank |
| rq_bank | input | log2(BANKS) | Read candidate bank |
| rq_port | input | log2(PORTS) | Read candidate port |
| rq_ready | output | 1 | Read candidate taken this cycle |
| wq_valid | input | 1 | Write candidate present |
| wq_rank | input | log2(RANKS) | Write candidate rank |
| wq_bank | input | log2(BANKS) | Write candidate bank |
| wq_port | input | log2(PORTS) | Write candidate port |
| wq_ready | output | 1 | Write candidate taken this cycle |
| mq_valid | output | 1 | A command is offered to the memory queue |
| mq_write | output | 1 | Offered command is a write |
| mq_rank | output | log2(RANKS) | Offered command rank |
| mq_bank | output | log2(BANKS) | Offered command bank |
| mq_port | output | log2(PORTS) | Offered command port |
| mq_ready | input | 1 | Memory queue accepts this cycle |

## Verification
Two situations are hard to reach from the ports: a balance pinned at its saturation limit, and a contest settled only by the entry two commands back. The stimulus reaches the first with a long read-only burst under a large write weight. It then switches to mix-first with both queues offering, so the number of writes before the first read shows whether the balance clipped or wrapped. Short directed sequences set up the history so that the second-slot bank match or the read-after-write rank term alone tips a contest. Around these, seeded sweeps over both policies, several weight pairs (including a zero weight) and narrow location ranges are checked cycle by cycle against a model computed from the requirements.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
   typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;
   localparam int COST_W = 3;
   localparam int COST_MAX = 4;
endpackage

// File: rtl/hbs_history.sv
module hbs_history
   import hbs_pkg::*;
#(
   parameter int RANK_W = 2,
   parameter int BANK_W = 2,
   parameter int PORT_W = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  op_e               in_op,
   input  logic [RANK_W-1:0] in_rank,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [PORT_W-1:0] in_port,
   output logic              last_v,
   output op_e               last_op,
   output logic [RANK_W-1:0] last_rank,
   output logic [BANK_W-1:0] last_bank,
   output logic [PORT_W-1:0] last_port,
   output logic              prev_v,
   output logic [RANK_W-1:0] prev_rank,
   output logic [BANK_W-1:0] prev_bank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_v    <= 1'b0;
         last_op   <= OP_READ;
         last_rank <= '0;
         last_bank <= '0;
         last_port <= '0;
         prev_v    <= 1'b0;
         prev_rank <= '0;
         prev_bank <= '0;
      end else if (push) begin
         prev_v    <= last_v;
         prev_rank <= last_rank;
         prev_bank <= last_bank;
         last_v    <= 1'b1;
         last_op   <= in_op;
         last_rank <= in_rank;
         last_bank <= in_bank;
         last_port <= in_port;
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(last_v) && $stable(last_rank) && $stable(last_bank)
                && $stable(prev_v) && $stable(prev_rank) && $stable(prev_bank));

   assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> last_v && prev_v == $past(last_v)
               && prev_rank == $past(last_rank) && prev_bank == $past(last_bank));

endmodule

// File: rtl/hbs_cost.sv
module hbs_cost
   import hbs_pkg::*;
#(
   parameter int PORTS  = 2,
   parameter int RANK_W = 2,
   parameter int BANK_W = 2,
   parameter int PORT_W = 1
)(
   input  op_e               c_op,
   input  logic [RANK_W-1:0] c_rank,
   input  logic [BANK_W-1:0] c_bank,
   input  logic [PORT_W-1:0] c_port,
   input  logic              last_v,
   input  op_e               last_op,
   input  logic [RANK_W-1:0] last_rank,
   input  logic [BANK_W-1:0] last_bank,
   input  logic [PORT_W-1:0] last_port,
   input  logic              prev_v,
   input  logic [RANK_W-1:0] prev_rank,
   input  logic [BANK_W-1:0] prev_bank,
   output logic [COST_W-1:0] cost
);

   logic hit_last, hit_prev, rd_after_wr, wr_after_rd;

   assign hit_last    = last_v && (last_rank == c_rank) && (last_bank == c_bank);
   assign hit_prev    = prev_v && (prev_rank == c_rank) && (prev_bank == c_bank);
   assign rd_after_wr = last_v && (c_op == OP_READ) && (last_op == OP_WRITE)
                        && (last_rank == c_rank);

   generate
      if (PORTS > 1) begin : g_port_turn
         assign wr_after_rd = last_v && (c_op == OP_WRITE) && (last_op == OP_READ)
                              && (last_port != c_port);
      end else begin : g_single_port
         assign wr_after_rd = 1'b0;
      end
   endgenerate

   assign cost = {hit_last, 1'b0} + COST_W'(hit_prev)
               + COST_W'(rd_after_wr) + COST_W'(wr_after_rd);

endmodule

// File: rtl/hbs_mix.sv
module hbs_mix
   import hbs_pkg::*;
#(
   parameter int WGT_W = 3,
   parameter int BAL_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  op_e              fire_op,
   input  logic [WGT_W-1:0] rd_wgt,
   input  logic [WGT_W-1:0] wr_wgt,
   output logic             want_rd,
   output logic             want_wr
);

   localparam int BAL_HI = (2 ** (BAL_W - 1)) - 1;
   localparam int BAL_LO = -(2 ** (BAL_W - 1));

   logic signed [BAL_W-1:0] bal, bal_d;
   int rd_eff, wr_eff, sum;

   always_comb begin
      rd_eff = (rd_wgt == '0) ? 1 : int'(rd_wgt);
      wr_eff = (wr_wgt == '0) ? 1 : int'(wr_wgt);
      sum    = int'(bal);
      if (fire) sum = (fire_op == OP_WRITE) ? sum - rd_eff : sum + wr_eff;
      if (sum > BAL_HI) sum = BAL_HI;
      if (sum < BAL_LO) sum = BAL_LO;
      bal_d  = BAL_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bal <= '0;
      else        bal <= bal_d;
   end

   assign want_rd = bal < 0;
   assign want_wr = bal > 0;

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(bal));

   assert_read_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire && fire_op == OP_READ |=> int'(bal) >= int'($past(bal)));

   assert_write_lowers_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire && fire_op == OP_WRITE |=> int'(bal) <= int'($past(bal)));

endmodule

// File: rtl/mem_hist_arbiter.sv
module mem_hist_arbiter
   import hbs_pkg::*;
#(
   parameter  int RANKS  = 4,
   parameter  int BANKS  = 4,
   parameter  int PORTS  = 2,
   parameter  int WGT_W  = 3,
   parameter  int BAL_W  = 6,
   localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mix_first,
   input  logic [WGT_W-1:0]  cfg_rd_weight,
   input  logic [WGT_W-1:0]  cfg_wr_weight,
   input  logic              rq_valid,
   input  logic [RANK_W-1:0] rq_rank,
   input  logic [BANK_W-1:0] rq_bank,
   input  logic [PORT_W-1:0] rq_port,
   output logic              rq_ready,
   input  logic              wq_valid,
   input  logic [RANK_W-1:0] wq_rank,
   input  logic [BANK_W-1:0] wq_bank,
   input  logic [PORT_W-1:0] wq_port,
   output logic              wq_ready,
   output logic              mq_valid,
   output logic              mq_write,
   output logic [RANK_W-1:0] mq_rank,
   output logic [BANK_W-1:0] mq_bank,
   output logic [PORT_W-1:0] mq_port,
   input  logic              mq_ready
);

   localparam int NCAND = 2;

   generate
      if (RANKS < 1 || BANKS < 1 || PORTS < 1) begin : g_bad_geometry
         $error("mem_hist_arbiter: geometry counts must be at least 1");
      end
      if (WGT_W < 1 || BAL_W <= WGT_W + 1 || BAL_W > 24) begin : g_bad_balance
         $error("mem_hist_arbiter: BAL_W must exceed WGT_W+1 and stay <= 24");
      end
   endgenerate

   // history outputs
   logic              h_last_v, h_prev_v;
   op_e               h_last_op;
   logic [RANK_W-1:0] h_last_rank, h_prev_rank;
   logic [BANK_W-1:0] h_last_bank, h_prev_bank;
   logic [PORT_W-1:0] h_last_port;

   // candidate vectors: index 0 read, index 1 write
   op_e               c_op   [NCAND];
   logic [RANK_W-1:0] c_rank [NCAND];
   logic [BANK_W-1:0] c_bank [NCAND];
   logic [PORT_W-1:0] c_port [NCAND];
   logic [COST_W-1:0] c_cost [NCAND];

   assign c_op[0]   = OP_READ;
   assign c_rank[0] = rq_rank;
   assign c_bank[0] = rq_bank;
   assign c_port[0] = rq_port;
   assign c_op[1]   = OP_WRITE;
   assign c_rank[1] = wq_rank;
   assign c_bank[1] = wq_bank;
   assign c_port[1] = wq_port;

   for (genvar g = 0; g < NCAND; g++) begin : g_cost
      hbs_cost #(.PORTS(PORTS), .RANK_W(RANK_W), .BANK_W(BANK_W), .PORT_W(PORT_W)) u_cost (
         .c_op      (c_op[g]),
         .c_rank    (c_rank[g]),
         .c_bank    (c_bank[g]),
         .c_port    (c_port[g]),
         .last_v    (h_last_v),
         .last_op   (h_last_op),
         .last_rank (h_last_rank),
         .last_bank (h_last_bank),
         .last_port (h_last_port),
         .prev_v    (h_prev_v),
         .prev_rank (h_prev_rank),
         .prev_bank (h_prev_bank),
         .cost      (c_cost[g])
      );
   end

   logic want_rd, want_wr, pick_wr, fire, rd_cheaper, wr_cheaper;

   assign rd_cheaper = c_cost[0] < c_cost[1];
   assign wr_cheaper = c_cost[1] < c_cost[0];

   always_comb begin
      if (!rq_valid)           pick_wr = wq_valid;
      else if (!wq_valid)      pick_wr = 1'b0;
      else if (!cfg_mix_first) pick_wr = wr_cheaper || (!rd_cheaper && want_wr);
      else                     pick_wr = want_wr || (!want_rd && wr_cheaper);
   end

   assign mq_valid = rq_valid || wq_valid;
   assign fire     = mq_valid && mq_ready;
   assign rq_ready = fire && !pick_wr;
   assign wq_ready = fire && pick_wr;
   assign mq_write = pick_wr;
   assign mq_rank  = pick_wr ? wq_rank : rq_rank;
   assign mq_bank  = pick_wr ? wq_bank : rq_bank;
   assign mq_port  = pick_wr ? wq_port : rq_port;

   hbs_history #(.RANK_W(RANK_W), .BANK_W(BANK_W), .PORT_W(PORT_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fire),
      .in_op     (pick_wr ? OP_WRITE : OP_READ),
      .in_rank   (mq_rank),
      .in_bank   (mq_bank),
      .in_port   (mq_port),
      .last_v    (h_last_v),
      .last_op   (h_last_op),
      .last_rank (h_last_rank),
      .last_bank (h_last_bank),
      .last_port (h_last_port),
      .prev_v    (h_prev_v),
      .prev_rank (h_prev_rank),
      .prev_bank (h_prev_bank)
   );

   hbs_mix #(.WGT_W(WGT_W), .BAL_W(BAL_W)) u_mix (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .fire_op (pick_wr ? OP_WRITE : OP_READ),
      .rd_wgt  (cfg_rd_weight),
      .wr_wgt  (cfg_wr_weight),
      .want_rd (want_rd),
      .want_wr (want_wr)
   );

   assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mq_ready |-> !rq_ready && !wq_ready);

   assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rq_ready, wq_ready}));

   assert_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mq_ready && (rq_valid || wq_valid) |-> $countones({rq_ready, wq_ready}) == 1);

   assert_single_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid && !wq_valid && mq_ready |-> rq_ready);

   assert_single_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wq_valid && !rq_valid && mq_ready |-> wq_ready);

   assert_cost_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(c_cost[0]) <= COST_MAX && int'(c_cost[1]) <= COST_MAX);

   assert_cost_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mix_first && rq_valid && wq_valid && mq_ready && rd_cheaper |-> rq_ready);

   assert_mix_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mix_first && rq_valid && wq_valid && mq_ready && want_wr |-> wq_ready);

   assert_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wq_ready |-> mq_write && mq_rank == wq_rank && mq_bank == wq_bank && mq_port == wq_port);

endmodule

// File: tb/mem_hist_arbiter_test.sv
module mem_hist_arbiter_test;

   localparam int WGT_W = 3;
   localparam int BAL_W = 6;
   localparam int BAL_HI = 31;
   localparam int BAL_LO = -32;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_mix_first;
   logic [2:0] cfg_rd_weight, cfg_wr_weight;
   logic       rq_valid, wq_valid, mq_ready;
   logic [1:0] rq_rank, rq_bank, wq_rank, wq_bank, mq_rank, mq_bank;
   logic       rq_port, wq_port, mq_port;
   logic       rq_ready, wq_ready, mq_valid, mq_write;

   mem_hist_arbiter #(.RANKS(4), .BANKS(4), .PORTS(2), .WGT_W(WGT_W), .BAL_W(BAL_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_mix_first(cfg_mix_first),
      .cfg_rd_weight(cfg_rd_weight), .cfg_wr_weight(cfg_wr_weight),
      .rq_valid(rq_valid), .rq_rank(rq_rank), .rq_bank(rq_bank), .rq_port(rq_port),
      .rq_ready(rq_ready),
      .wq_valid(wq_valid), .wq_rank(wq_rank), .wq_bank(wq_bank), .wq_port(wq_port),
      .wq_ready(wq_ready),
      .mq_valid(mq_valid), .mq_write(mq_write), .mq_rank(mq_rank), .mq_bank(mq_bank),
      .mq_port(mq_port), .mq_ready(mq_ready)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit [31:0] seed = 32'h1234_5678;

   // reference model state, written from the requirements
   bit m_v[2];
   bit m_w[2];
   int m_rank[2], m_bank[2], m_port[2];
   int m_bal;
   int wgt_r, wgt_w;

   function automatic int unsigned rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed >> 8;
   endfunction

   function automatic int cost_of(bit w, int r, int b, int p);
      int c = 0;
      if (m_v[0] && m_rank[0] == r && m_bank[0] == b) c += 2;
      if (m_v[1] && m_rank[1] == r && m_bank[1] == b) c += 1;
      if (m_v[0] && !w && m_w[0] && m_rank[0] == r) c += 1;
      if (m_v[0] && w && !m_w[0] && m_port[0] != p) c += 1;
      return c;
   endfunction

   task automatic model_clear();
      for (int k = 0; k < 2; k++) begin
         m_v[k] = 0; m_w[k] = 0; m_rank[k] = 0; m_bank[k] = 0; m_port[k] = 0;
      end
      m_bal = 0;
   endtask

   task automatic do_reset(input int wr_r, input int wr_w);
      @(negedge clk);
      rst_n = 1'b0;
      rq_valid = 0; wq_valid = 0; mq_ready = 1;
      rq_rank = 0; rq_bank = 0; rq_port = 0; wq_rank = 0; wq_bank = 0; wq_port = 0;
      cfg_mix_first = 0;
      wgt_r = wr_r; wgt_w = wr_w;
      cfg_rd_weight = 3'(wr_r); cfg_wr_weight = 3'(wr_w);
      model_clear();
      @(negedge clk);
      #1;
      checks++;
      if (mq_valid !== 1'b0 || rq_ready !== 1'b0 || wq_ready !== 1'b0) begin
         fails++;
         $display("FAIL R1: in reset v/rr/wr=%b%b%b expected 000", mq_valid, rq_ready, wq_ready);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input bit rv, input bit wv, input bit rdy,
                       input int rr, input int rb, input int rp,
                       input int wr, input int wb, input int wp,
                       input bit pol, input string tag);
      int cr, cw, rde, wre;
      bit exp_w, exp_v, fire, ok;
      string t;
      @(negedge clk);
      rq_valid = rv; wq_valid = wv; mq_ready = rdy; cfg_mix_first = pol;
      rq_rank = rr[1:0]; rq_bank = rb[1:0]; rq_port = rp[0];
      wq_rank = wr[1:0]; wq_bank = wb[1:0]; wq_port = wp[0];
      #2;
      cr = cost_of(1'b0, rr, rb, rp);
      cw = cost_of(1'b1, wr, wb, wp);
      exp_v = rv | wv;
      if (!rv) exp_w = wv;
      else if (!wv) exp_w = 1'b0;
      else if (!pol) begin
         if (cr < cw) exp_w = 1'b0;
         else if (cw < cr) exp_w = 1'b1;
         else exp_w = (m_bal > 0);
      end else begin
         if (m_bal > 0) exp_w = 1'b1;
         else if (m_bal < 0) exp_w = 1'b0;
         else exp_w = (cw < cr);
      end
      fire = exp_v & rdy;
      t = tag;
      if (t == "") begin
         if (!exp_v) t = "R3";
         else if (!rdy) t = "R4";
         else if (rv ^ wv) t = "R2,R10";
         else t = pol ? "R7,R11" : "R6,R11";
      end
      checks++;
      ok = (mq_valid === exp_v) && (rq_ready === (fire && !exp_w)) && (wq_ready === (fire && exp_w));
      if (exp_v)
         ok = ok && (mq_write === exp_w)
                 && (int'(mq_rank) == (exp_w ? wr : rr))
                 && (int'(mq_bank) == (exp_w ? wb : rb))
                 && (int'(mq_port) == (exp_w ? wp : rp));
      if (!ok) begin
         fails++;
         $display("FAIL %s: got v=%b rr=%b wr=%b w=%b loc=%0d/%0d/%0d expected v=%b rr=%b wr=%b w=%b loc=%0d/%0d/%0d (cost r=%0d w=%0d bal=%0d)",
                  t, mq_valid, rq_ready, wq_ready, mq_write, mq_rank, mq_bank, mq_port,
                  exp_v, fire && !exp_w, fire && exp_w, exp_w,
                  exp_w ? wr : rr, exp_w ? wb : rb, exp_w ? wp : rp, cr, cw, m_bal);
      end
      if (fire) begin
         m_v[1] = m_v[0]; m_w[1] = m_w[0];
         m_rank[1] = m_rank[0]; m_bank[1] = m_bank[0]; m_port[1] = m_port[0];
         m_v[0] = 1; m_w[0] = exp_w;
         m_rank[0] = exp_w ? wr : rr;
         m_bank[0] = exp_w ? wb : rb;
         m_port[0] = exp_w ? wp : rp;
         rde = (wgt_r == 0) ? 1 : wgt_r;
         wre = (wgt_w == 0) ? 1 : wgt_w;
         m_bal = exp_w ? m_bal - rde : m_bal + wre;
         if (m_bal > BAL_HI) m_bal = BAL_HI;
         if (m_bal < BAL_LO) m_bal = BAL_LO;
      end
   endtask

   task automatic sweep(input int n, input bit pol, input int span);
      for (int i = 0; i < n; i++) begin
         step((rnd() % 4) != 0, (rnd() % 4) != 0, (rnd() % 8) != 0,
              int'(rnd() % 4), int'(rnd() % span), int'(rnd() % 2),
              int'(rnd() % 4), int'(rnd() % span), int'(rnd() % 2), pol, "");
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int wr_pairs [4][2];
      wr_pairs = '{'{1, 1}, '{2, 1}, '{1, 2}, '{0, 3}};

      // R1: reset state and first decision with empty history
      do_reset(1, 1);
      step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
      step(1, 1, 1, 0, 0, 0, 1, 1, 1, 0, "R1");

      // R5: second-slot match and read-after-write term decide
      do_reset(1, 1);
      step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
      step(0, 1, 1, 0, 0, 0, 1, 1, 1, 0, "R2");
      step(1, 1, 1, 1, 1, 0, 0, 0, 1, 0, "R5");   // read 3 vs write 1 -> write
      // R9: history shifted; write hits the older slot, read is free
      step(1, 1, 1, 2, 2, 0, 1, 1, 0, 0, "R9");
      // R4: memory queue stalls, nothing moves
      step(1, 1, 0, 3, 3, 1, 3, 2, 1, 0, "R4");
      step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
      step(1, 1, 1, 2, 2, 1, 2, 2, 1, 1, "R7");

      // R8: balance saturation under a large write weight, then mix-first drain
      do_reset(1, 7);
      for (int i = 0; i < 8; i++) step(1, 0, 1, i % 4, 0, 0, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 40; i++) step(1, 1, 1, 3, 3, 0, 3, 3, 0, 1, "R8");

      // sweeps over policies, weight pairs (one with a zero weight) and location ranges
      for (int pol = 0; pol < 2; pol++) begin
         for (int c = 0; c < 4; c++) begin
            do_reset(wr_pairs[c][0], wr_pairs[c][1]);
            sweep(1200, pol[0], (c % 2 == 0) ? 2 : 4);
         end
      end

      // R10: a continuous offer with ready always produces one issue per cycle
      do_reset(2, 1);
      for (int i = 0; i < 20; i++) step(1, 1, 1, i % 4, i % 3, i % 2, (i + 1) % 4, i % 2, 0, 0, "R10");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule